// File: doc/BRIEF.md
# Byte-Frame Asynchronous Serial Port

This block is a full-duplex asynchronous serial port built like the fixed-rate byte mode of a classic 8-bit controller. It sends and receives 10-bit frames: a low start bit, eight data bits sent least significant bit first, and a high stop bit. The bit clock comes from an external timer-overflow strobe. A 16x oversampling tick is taken from that strobe directly, or from every second strobe, and one free-running 4-bit phase counter divides the tick into bit periods. The transmitter and the receiver share this counter.

A write to the data register starts a transmission. The start bit leaves on the next roll-over of the phase counter, so the frame follows the counter and not the write. When the receiver is enabled, a falling edge on the synchronized input clears the phase counter, so that its roll-overs line up with the sender's bit boundaries. Each bit is sampled three times near the middle of its period, and the three samples are combined by majority vote. The stop bit is kept as a ninth received bit. Transmit-done and receive-done flags stay set until software writes them.

Top module: `mcu_serial_port`

## Requirements
- R1: `txd_o` is 1 after reset. A transmitted frame is start bit 0, then data bits 0..7, then stop bit 1.
- R2: The bit period is 16 baud-tick strobes when `dbl_rate_i` is 1 and 32 strobes when it is 0. Both directions use this period.
- R3: A write to address 0 loads a frame. The start bit appears on the first phase-counter roll-over after the write, which is 1 to one bit period later. Each later bit appears exactly one bit period after the one before it, and `txd_o` changes at no other time.
- R4: `tx_done_o` rises in the same cycle that the stop bit is driven, nine bit periods after the start bit appears, and not earlier.
- R5: Reception runs only while the control bit rx_en (address 1, bit 0) is 1. With rx_en at 0, a frame on `rxd_i` leaves `rx_done_o` at 0 and the receive buffer unchanged.
- R6: `rxd_i` passes through a two-flop synchronizer. A falling edge clears the phase counter. Each bit is the majority of the samples taken in phase states 7, 8 and 9, so a one-cycle glitch has no effect. The data bits are assembled LSB first into the receive buffer (read at address 0). The stop bit goes into the ninth-bit field (address 1, bit 3), and `rx_done_o` is set.
- R7: If the majority value of the start bit is 1, nothing is received, and the receiver waits for the next falling edge.
- R8: A frame that finishes while `rx_done_o` is already 1 is discarded. The buffer and the ninth bit keep their values.
- R9: The flags are cleared only by software. A write to address 1 loads rx_en from bit 0, tx_done from bit 1 and rx_done from bit 2; if hardware sets a flag in the same cycle, the hardware set wins. A read of address 1 returns {ninth, rx_done, tx_done, rx_en} in bits 3..0, and all of these are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Timer-overflow strobe, one cycle wide |
| dbl_rate_i | input | 1 | 1: 16 strobes per bit, 0: 32 strobes per bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0: data register, 1: control/status register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |

## Verification
The assertions assume that the baud strobe and all register accesses are synchronous to `clk_i`. They also assume that a flag falls only in the cycle after a control write, so the only way the stimulus clears a flag is a write to address 1. The stimulus holds `baud_tick_i` high in every cycle, which makes the bit period exactly 16 or 32 clocks. It never drives the receive line during a transmission, because a start edge would realign the shared counter. Every received frame is driven whole, with bit edges exactly one period apart.

// File: rtl/mcu_sp_pkg.sv
package mcu_sp_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int CTRL_RXEN   = 0;
  localparam int CTRL_TXDONE = 1;
  localparam int CTRL_RXDONE = 2;
  localparam int CTRL_NINTH  = 3;
  typedef enum logic {RX_IDLE, RX_BUSY} rx_state_e;
endpackage

// File: rtl/mcu_sp_baud.sv
module mcu_sp_baud #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             baud_tick_i,
  input  logic             dbl_rate_i,
  input  logic             realign_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] phase_o,
  output logic             roll_o
);
  logic             half_q;
  logic [CNT_W-1:0] phase_q;

  assign tick_o  = baud_tick_i & (dbl_rate_i | half_q);
  assign roll_o  = tick_o & (phase_q == '1) & ~realign_i;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      if (baud_tick_i) half_q <= ~half_q;
      if (realign_i)   phase_q <= '0;
      else if (tick_o) phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/mcu_sp_tx.sv
module mcu_sp_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              roll_i,
  output logic              txd_o,
  output logic              done_set_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shift_q;
  logic [LEFT_W-1:0]  left_q;
  logic               txd_q;

  assign txd_o      = txd_q;
  assign done_set_o = roll_i & ~load_i & (left_q == LEFT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      left_q  <= '0;
      txd_q   <= 1'b1;
    end else if (load_i) begin
      shift_q <= {1'b1, data_i, 1'b0};
      left_q  <= LEFT_W'(FRAME_W);
    end else if (roll_i && left_q != '0) begin
      txd_q   <= shift_q[0];
      shift_q <= shift_q >> 1;
      left_q  <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/mcu_sp_rx.sv
module mcu_sp_rx
  import mcu_sp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  phase_i,
  input  logic              full_i,
  output logic              realign_o,
  output logic              done_set_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ninth_o
);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID0 = CNT_W'((1 << CNT_W) / 2 - 1);
  localparam logic [CNT_W-1:0] MID1 = MID0 + CNT_W'(1);
  localparam logic [CNT_W-1:0] MID2 = MID0 + CNT_W'(2);

  logic [1:0]        sync_q;
  logic              prev_q, rxd_s;
  rx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        smp_q;
  logic [DATA_W-1:0] shreg_q, buf_q;
  logic              ninth_q, maj, decide;

  assign rxd_s      = sync_q[1];
  assign realign_o  = en_i & (state_q == RX_IDLE) & prev_q & ~rxd_s;
  assign maj        = (smp_q[0] & smp_q[1]) | (smp_q[0] & rxd_s) | (smp_q[1] & rxd_s);
  assign decide     = en_i & (state_q == RX_BUSY) & tick_i & (phase_i == MID2);
  assign done_set_o = decide & (idx_q == LAST) & ~full_i;
  assign data_o     = buf_q;
  assign ninth_o    = ninth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      state_q <= RX_IDLE;
      idx_q   <= '0;
      smp_q   <= '0;
      shreg_q <= '0;
      buf_q   <= '0;
      ninth_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      prev_q <= rxd_s;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (state_q == RX_IDLE) begin
        if (realign_o) begin
          state_q <= RX_BUSY;
          idx_q   <= '0;
        end
      end else begin
        if (tick_i && phase_i == MID0) smp_q[0] <= rxd_s;
        if (tick_i && phase_i == MID1) smp_q[1] <= rxd_s;
        if (decide) begin
          if ((idx_q == '0 && maj) || idx_q == LAST) begin
            state_q <= RX_IDLE;  // false start or frame end
          end else begin
            if (idx_q != '0) shreg_q <= {maj, shreg_q[DATA_W-1:1]};
            idx_q <= idx_q + 1'b1;
          end
        end
      end
      if (done_set_o) begin
        buf_q   <= shreg_q;
        ninth_q <= maj;
      end
    end
  end
endmodule

// File: rtl/mcu_serial_port.sv
module mcu_serial_port
  import mcu_sp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              dbl_rate_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              tx_done_o,
  output logic              rx_done_o
);
  logic             tick16, roll, realign;
  logic [CNT_W-1:0] phase;
  logic             tx_set, rx_set, rx_en_q, tx_done_q, rx_done_q, ninth;
  logic [DATA_W-1:0] rx_buf, ctrl_rd;
  logic             data_wr, ctrl_wr;

  assign data_wr = reg_we_i & (reg_addr_i == ADDR_DATA);
  assign ctrl_wr = reg_we_i & (reg_addr_i == ADDR_CTRL);

  mcu_sp_baud #(.CNT_W(CNT_W)) i_baud (
    .clk_i, .rst_ni, .baud_tick_i, .dbl_rate_i,
    .realign_i(realign), .tick_o(tick16), .phase_o(phase), .roll_o(roll)
  );

  mcu_sp_tx #(.DATA_W(DATA_W)) i_tx (
    .clk_i, .rst_ni, .load_i(data_wr), .data_i(reg_wdata_i),
    .roll_i(roll), .txd_o, .done_set_o(tx_set)
  );

  mcu_sp_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_rx (
    .clk_i, .rst_ni, .en_i(rx_en_q), .rxd_i, .tick_i(tick16), .phase_i(phase),
    .full_i(rx_done_q), .realign_o(realign), .done_set_o(rx_set),
    .data_o(rx_buf), .ninth_o(ninth)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q   <= 1'b0;
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
    end else begin
      if (ctrl_wr) rx_en_q <= reg_wdata_i[CTRL_RXEN];
      tx_done_q <= tx_set | (ctrl_wr ? reg_wdata_i[CTRL_TXDONE] : tx_done_q);
      rx_done_q <= rx_set | (ctrl_wr ? reg_wdata_i[CTRL_RXDONE] : rx_done_q);
    end
  end

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[CTRL_RXEN]   = rx_en_q;
    ctrl_rd[CTRL_TXDONE] = tx_done_q;
    ctrl_rd[CTRL_RXDONE] = rx_done_q;
    ctrl_rd[CTRL_NINTH]  = ninth;
    reg_rdata_o = (reg_addr_i == ADDR_CTRL) ? ctrl_rd : rx_buf;
  end

  assign tx_done_o = tx_done_q;
  assign rx_done_o = rx_done_q;
endmodule

// File: rtl/mcu_sp_checker.sv
module mcu_sp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              baud_tick_i,
  input logic              reg_we_i,
  input logic              reg_addr_i,
  input logic              txd_o,
  input logic              tx_done_o,
  input logic              rx_done_o,
  input logic              tick16,
  input logic              roll,
  input logic              rx_en_q,
  input logic [DATA_W-1:0] rx_buf
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i & reg_addr_i;

  p_tick_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick16 |-> baud_tick_i);

  p_txd_on_roll_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> $past(roll));

  p_tx_done_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_done_o) && !$past(ctrl_wr)) |-> (txd_o && $past(roll)));

  p_rx_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rx_done_o) && !$past(ctrl_wr)) |-> $past(rx_en_q));

  p_buf_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rx_done_o) |-> $stable(rx_buf));

  p_flag_sw_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tx_done_o) || $fell(rx_done_o)) |-> $past(ctrl_wr));
endmodule

bind mcu_serial_port mcu_sp_checker #(.DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .baud_tick_i(baud_tick_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .txd_o(txd_o),
  .tx_done_o(tx_done_o), .rx_done_o(rx_done_o), .tick16(tick16),
  .roll(roll), .rx_en_q(rx_en_q), .rx_buf(rx_buf)
);

// File: tb/test_mcu_serial_port.sv
module test_mcu_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       dbl = 1'b1;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd, tx_done, rx_done;
  int         checks = 0;
  int         failures = 0;
  bit         done_flag = 0;

  always #5 clk = ~clk;

  mcu_serial_port i_mcu_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(baud_tick), .dbl_rate_i(dbl),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rxd_i(rxd), .txd_o(txd), .tx_done_o(tx_done), .rx_done_o(rx_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  function automatic int period();
    return dbl ? 16 : 32;
  endfunction

  task automatic tx_frame(input logic [7:0] d, input logic rxen);
    int p = period();
    int lat = 0;
    logic [9:0] fr = {1'b1, d, 1'b0};
    wr(1'b1, {7'd0, rxen});
    wr(1'b0, d);
    check(txd === 1'b1, "R3 txd before first roll", txd, 1);
    while (txd !== 1'b0 && lat <= 2 * p) begin
      @(negedge clk);
      lat++;
    end
    check(lat >= 1 && lat <= p, "R3 start latency", lat, p);
    for (int c = 1; c <= 9 * p; c++) begin
      @(negedge clk);
      if (c % p == 0) check(txd === fr[c / p], "R1 R2 frame bit", txd, fr[c / p]);
      if (c == 9 * p - 1) check(tx_done === 1'b0, "R4 tx_done early", tx_done, 0);
      if (c == 9 * p) check(tx_done === 1'b1, "R4 tx_done with stop", tx_done, 1);
    end
  endtask

  task automatic rx_drive(input logic [7:0] d, input logic stop, input bit glitch);
    int p = period();
    logic [9:0] fr = {stop, d, 1'b0};
    for (int b = 0; b < 10; b++)
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        rxd = (glitch && b == 4 && c == 11) ? ~fr[b] : fr[b];
      end
    @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_expect(input logic [7:0] d, input logic ninth, input logic done, input string tag);
    logic [7:0] v;
    check(rx_done === done, {tag, " rx_done"}, rx_done, done);
    rd(1'b0, v);
    check(v === d, {tag, " buffer"}, v, d);
    rd(1'b1, v);
    check(v[3] === ninth, {tag, " ninth"}, v[3], ninth);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R1 reset txd", txd, 1);
    rd(1'b1, v);
    check(v === 8'h00, "R9 reset ctrl", v, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_done === 1'b0 && rx_done === 1'b0, "R9 flags after reset", {tx_done, rx_done}, 0);

    // transmit sweep, 16 strobes per bit
    for (int i = 0; i < 256; i++) tx_frame(8'(i), 1'b0);
    // 32 strobes per bit
    dbl = 1'b0;
    tx_frame(8'hA5, 1'b0);
    tx_frame(8'h3C, 1'b0);
    dbl = 1'b1;
    rd(1'b1, v);
    check(v[1] === 1'b1, "R9 tx_done held", v[1], 1);

    // receiver disabled
    wr(1'b1, 8'h00);
    check(tx_done === 1'b0, "R9 sw clear tx_done", tx_done, 0);
    rx_drive(8'h5A, 1'b1, 0);
    rx_expect(8'h00, 1'b0, 1'b0, "R5 disabled");

    // receive sweep
    wr(1'b1, 8'h01);
    for (int i = 0; i < 256; i++) begin
      rx_drive(8'(i), 1'b1, (i % 2) == 1);
      rx_expect(8'(i), 1'b1, 1'b1, "R6 sweep");
      wr(1'b1, 8'h01);
    end
    rx_drive(8'hC3, 1'b0, 0);
    rx_expect(8'hC3, 1'b0, 1'b1, "R6 stop zero");
    wr(1'b1, 8'h01);
    check(rx_done === 1'b0, "R9 sw clear rx_done", rx_done, 0);

    // false start
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    rx_expect(8'hC3, 1'b0, 1'b0, "R7 false start");
    rx_drive(8'h81, 1'b1, 0);
    rx_expect(8'h81, 1'b1, 1'b1, "R7 rearmed");

    // overrun
    rx_drive(8'h7E, 1'b0, 0);
    rx_expect(8'h81, 1'b1, 1'b1, "R8 overrun");
    wr(1'b1, 8'h01);

    // 32 strobes per bit on receive
    dbl = 1'b0;
    rx_drive(8'h96, 1'b1, 1);
    rx_expect(8'h96, 1'b1, 1'b1, "R2 slow rx");
    wr(1'b1, 8'h01);
    rx_drive(8'h2D, 1'b1, 0);
    rx_expect(8'h2D, 1'b1, 1'b1, "R2 slow rx b");
    finish_run();
  end
endmodule